// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves data on behalf of a processor without the processor touching each item. Two independent channels each hold a source address, a destination address, a transfer count and a control word. Once a channel is armed, the controller requests the single shared bus, waits for the grant, and then copies one item per transfer: a read from the source followed by a write to the destination. Memory-to-memory, I/O-to-memory and I/O-to-I/O moves are all the same operation. The only difference is whether each address steps forward or stays fixed on a port.

Software programs a channel through a small write port and arms it with a start bit. A channel can also be configured so that each transfer waits for its own external request line. When both channels want the bus, a global mode input picks between strict priority and alternation. Each channel can either give the bus back after every item or keep it until its whole block is finished. Each channel raises its own maskable interrupt when its block completes or when a misaligned address stops it.

Top module: `dma_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `bus_req`, `mem_en`, `irq` and `err_flag` are all low.
- R2: Register index 2 loads a 16-bit count. A value N in 1..65535 yields exactly N transfers, and 0 yields 65,536 transfers.
- R3: Control bits [1:0] select the item size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Each transfer is one read cycle at the source (`mem_we`=0), then one write cycle at the destination (`mem_we`=1) carrying the read data right-justified. After each transfer both addresses advance by the item size.
- R4: Control bit 2 keeps the source address fixed, and control bit 3 keeps the destination address fixed.
- R5: With `prio_rr` low, channel 0 wins every arbitration in which both channels are ready.
- R6: With `prio_rr` high, a channel that has just been served loses the next arbitration in which both channels are ready.
- R7: With control bit 4 clear, `bus_req` falls after every single transfer.
- R8: With control bit 4 set, `bus_req` stays high from the first transfer of the block to the last one, and falls only once.
- R9: Control bit 7 written as 1 arms the channel. With control bit 5 set, an armed channel starts a transfer only while its `ext_req` bit is high.
- R10: A channel's `irq` bit is high while its done or error flag is set and control bit 6 (interrupt enable) is 1. With bit 6 at 0 the flag is still kept. Writing control bit 8 as 1 clears both flags.
- R11: If an armed channel has an address misaligned for its size, or size code 3, its `err_flag` bit is set and the channel disarms without any memory cycle.
- R12: No memory cycle occurs while `bus_gnt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_rr | input | 1 | 0 = fixed priority, 1 = alternating priority |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel selected for the write |
| cfg_reg | input | 2 | 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Write data |
| ext_req | input | 2 | Per-channel external transfer request |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_en | output | 1 | Memory cycle active |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Item size code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified, same cycle |
| irq | output | 2 | Per-channel interrupt |
| err_flag | output | 2 | Per-channel alignment error flag |

## Verification
The hardest situation to reach from the ports is true contention: both channels ready in the same cycle while the engine sits idle. A software start arms one channel before the other, so starts alone cannot produce it. The bench therefore arms both channels in external-request mode with their request lines low, then raises both lines on the same edge. The order of write addresses then shows the arbitration outcome under each priority mode. A sweep over size, fixed-address options, bus-holding mode and small counts checks the memory contents against an arithmetic copy model, and one burst run checks the 65,536-transfer case.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int NCH = 2;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int CW  = 16;

    localparam logic [1:0] REG_SRC  = 2'd0;
    localparam logic [1:0] REG_DST  = 2'd1;
    localparam logic [1:0] REG_CNT  = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    localparam int CB_SFIX  = 2;
    localparam int CB_DFIX  = 3;
    localparam int CB_BURST = 4;
    localparam int CB_EXT   = 5;
    localparam int CB_IEN   = 6;
    localparam int CB_START = 7;
    localparam int CB_CLR   = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_WR
    } eng_state_e;

    typedef struct packed {
        xfer_size_e size;
        logic       src_fix;
        logic       dst_fix;
        logic       burst;
        logic       ext_mode;
        logic       irq_en;
    } chan_ctrl_t;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        xfer_size_e    size;
        logic          burst;
        logic          last;
    } chan_view_t;

    function automatic logic [2:0] size_bytes(xfer_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic addr_bad(logic [AW-1:0] a, xfer_size_e s);
        case (s)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return a[0];
            SZ_WORD: return |a[1:0];
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int CNT_W  = CW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_reg,
    input  logic [31:0]       wr_data,
    input  logic              ext_req,
    input  logic              step,
    output logic              pending,
    output chan_view_t        view,
    output logic              irq,
    output logic              err
);
    localparam int LEFT_W = CNT_W + 1;
    localparam logic [LEFT_W-1:0] FULL_BLOCK = LEFT_W'(1) << CNT_W;

    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LEFT_W-1:0] left_q;
    chan_ctrl_t        ctrl_q;
    logic              armed_q, done_q, err_q;
    logic              misaligned;
    logic [ADDR_W-1:0] inc;

    assign misaligned = addr_bad(src_q, ctrl_q.size) | addr_bad(dst_q, ctrl_q.size);
    assign inc        = ADDR_W'(size_bytes(ctrl_q.size));

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            left_q  <= '0;
            ctrl_q  <= '0;
            armed_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (step) begin
                if (!ctrl_q.src_fix) src_q <= src_q + inc;
                if (!ctrl_q.dst_fix) dst_q <= dst_q + inc;
                left_q <= left_q - LEFT_W'(1);
                if (left_q == LEFT_W'(1)) begin
                    armed_q <= 1'b0;
                    done_q  <= 1'b1;
                end
            end else if (armed_q && misaligned) begin
                armed_q <= 1'b0;
                err_q   <= 1'b1;
            end
            if (wr_en) begin
                case (wr_reg)
                    REG_SRC: src_q <= wr_data[ADDR_W-1:0];
                    REG_DST: dst_q <= wr_data[ADDR_W-1:0];
                    REG_CNT: cnt_q <= wr_data[CNT_W-1:0];
                    default: begin
                        ctrl_q.size     <= xfer_size_e'(wr_data[1:0]);
                        ctrl_q.src_fix  <= wr_data[CB_SFIX];
                        ctrl_q.dst_fix  <= wr_data[CB_DFIX];
                        ctrl_q.burst    <= wr_data[CB_BURST];
                        ctrl_q.ext_mode <= wr_data[CB_EXT];
                        ctrl_q.irq_en   <= wr_data[CB_IEN];
                        if (wr_data[CB_CLR] || wr_data[CB_START]) begin
                            done_q <= 1'b0;
                            err_q  <= 1'b0;
                        end
                        if (wr_data[CB_START]) begin
                            armed_q <= 1'b1;
                            left_q  <= (cnt_q == '0) ? FULL_BLOCK : LEFT_W'(cnt_q);
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        pending    = armed_q && !misaligned && (!ctrl_q.ext_mode || ext_req);
        view.src   = src_q;
        view.dst   = dst_q;
        view.size  = ctrl_q.size;
        view.burst = ctrl_q.burst;
        view.last  = (left_q == LEFT_W'(1));
        irq        = ctrl_q.irq_en && (done_q || err_q);
        err        = err_q;
    end
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
    import dma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           rr_mode,
    input  logic [NCH-1:0] pend,
    input  logic           take,
    output logic           valid,
    output logic           idx
);
    logic last_q;

    always_comb begin
        valid = |pend;
        if (pend == 2'b11) idx = rr_mode ? ~last_q : 1'b0;
        else               idx = pend[1] & ~pend[0];
    end

    always_ff @(posedge clk) begin
        if (rst)       last_q <= 1'b1;
        else if (take) last_q <= idx;
    end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           grant_valid,
    input  logic           grant_idx,
    input  chan_view_t     view [NCH],
    input  logic           bus_gnt,
    input  logic [DW-1:0]  mem_rdata,
    output logic           take,
    output logic [NCH-1:0] step,
    output logic           bus_req,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_wdata
);
    eng_state_e    state_q;
    logic          cur_q;
    logic [DW-1:0] data_q;
    chan_view_t    cv;

    assign cv = view[cur_q];

    always_comb begin
        bus_req   = (state_q != ST_IDLE);
        mem_en    = bus_gnt && (state_q == ST_RD || state_q == ST_WR);
        mem_we    = bus_gnt && (state_q == ST_WR);
        mem_addr  = (state_q == ST_WR) ? cv.dst : cv.src;
        mem_size  = cv.size;
        mem_wdata = data_q;
        take      = (state_q == ST_IDLE) && grant_valid;
        step      = '0;
        if (state_q == ST_WR && bus_gnt) step[cur_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (take) begin
                    cur_q   <= grant_idx;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: if (bus_gnt) state_q <= ST_RD;
                ST_RD: if (bus_gnt) begin
                    data_q  <= mem_rdata;
                    state_q <= ST_WR;
                end
                default: if (bus_gnt) begin
                    state_q <= (cv.burst && !cv.last) ? ST_RD : ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/dma_top.sv
module dma_top
    import dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        prio_rr,
    input  logic        cfg_we,
    input  logic        cfg_ch,
    input  logic [1:0]  cfg_reg,
    input  logic [31:0] cfg_wdata,
    input  logic [1:0]  ext_req,
    output logic        bus_req,
    input  logic        bus_gnt,
    output logic        mem_en,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_size,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic [1:0]  irq,
    output logic [1:0]  err_flag
);
    logic [NCH-1:0] pend, step;
    chan_view_t     views [NCH];
    logic           take, gvalid, gidx;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_channel #(.ADDR_W(AW), .CNT_W(CW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cfg_we && (cfg_ch == c[0])),
            .wr_reg  (cfg_reg),
            .wr_data (cfg_wdata),
            .ext_req (ext_req[c]),
            .step    (step[c]),
            .pending (pend[c]),
            .view    (views[c]),
            .irq     (irq[c]),
            .err     (err_flag[c])
        );
    end

    dma_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .rr_mode (prio_rr),
        .pend    (pend),
        .take    (take),
        .valid   (gvalid),
        .idx     (gidx)
    );

    dma_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .grant_valid (gvalid),
        .grant_idx   (gidx),
        .view        (views),
        .bus_gnt     (bus_gnt),
        .mem_rdata   (mem_rdata),
        .take        (take),
        .step        (step),
        .bus_req     (bus_req),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_size    (mem_size),
        .mem_wdata   (mem_wdata)
    );
endmodule

// File: rtl/dma_checker.sv
module dma_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_gnt,
    input logic        mem_en,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [1:0]  mem_size
);
    // R12
    gnt_before_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (bus_gnt && bus_req));

    // R3
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we && bus_gnt) |=> (mem_en && mem_we));

    // R7
    req_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> $past(mem_we));

    // R11
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_size == 2'd2) |-> (mem_addr[1:0] == 2'd0));

    // R11
    half_align_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_size == 2'd1) |-> !mem_addr[0]);

    // R3
    size_code_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (mem_size != 2'd3));
endmodule

bind dma_top dma_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_size (mem_size)
);

// File: tb/tb_dma_top.sv
module tb_dma_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prio_rr = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_ch = 1'b0;
    logic [1:0]  cfg_reg = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  ext_req = 2'b00;
    logic        bus_req, bus_gnt, mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size, irq, err_flag;
    logic        gnt_hold = 1'b0;
    logic        tb_clr = 1'b0;

    logic [7:0]  mem [0:255];
    logic [7:0]  exp_m [0:255];
    logic [7:0]  wlog [0:63];
    int          wcnt, acc, falls;
    logic        req_d;
    int          checks = 0, errors = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;
    assign bus_gnt = bus_req && !gnt_hold;

    dma_top dut (.*);

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] pat(int i);
        return 8'(i * 7 + 3);
    endfunction

    always_comb begin
        mem_rdata = '0;
        for (int k = 0; k < 4; k++)
            if (k < nbytes(mem_size)) mem_rdata[8*k +: 8] = mem[mem_addr[7:0] + 8'(k)];
    end

    always @(posedge clk) begin
        req_d <= bus_req;
        if (tb_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
            wcnt <= 0; acc <= 0; falls <= 0;
        end else begin
            if (mem_en) acc <= acc + 1;
            if (mem_en && mem_we) begin
                if (wcnt < 64) wlog[wcnt] <= mem_addr[7:0];
                wcnt <= wcnt + 1;
                for (int k = 0; k < 4; k++)
                    if (k < nbytes(mem_size)) mem[mem_addr[7:0] + 8'(k)] <= mem_wdata[8*k +: 8];
            end
            if (req_d && !bus_req) falls <= falls + 1;
        end
    end

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(logic ch, logic [1:0] r, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_reg = r; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctl(int sz, bit sf, bit df, bit bu, bit ex, bit ie, bit st, bit cl);
        return 32'(sz) | (32'(sf) << 2) | (32'(df) << 3) | (32'(bu) << 4) |
               (32'(ex) << 5) | (32'(ie) << 6) | (32'(st) << 7) | (32'(cl) << 8);
    endfunction

    task automatic clear_mon();
        @(negedge clk); tb_clr = 1'b1;
        @(negedge clk); tb_clr = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 6) begin
            @(negedge clk);
            if (bus_req) q = 0; else q++;
        end
    endtask

    task automatic setup(logic ch, int src, int dst, int cnt);
        wr(ch, 2'd0, 32'(src));
        wr(ch, 2'd1, 32'(dst));
        wr(ch, 2'd2, 32'(cnt));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(bus_req == 0 && mem_en == 0 && irq == 0 && err_flag == 0, "R1 during reset", 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check(bus_req == 0 && mem_en == 0 && irq == 0 && err_flag == 0, "R1 after reset", 0, 0);

        // R3 R4 R7 R8 sweep
        for (int sz = 0; sz < 3; sz++)
            for (int sf = 0; sf < 2; sf++)
                for (int df = 0; df < 2; df++)
                    for (int cnt = 1; cnt < 4; cnt++) begin
                        automatic int b = nbytes(2'(sz));
                        automatic bit bu = (cnt + sz) % 2 == 0;
                        automatic int bad = 0;
                        for (int i = 0; i < 256; i++) exp_m[i] = pat(i);
                        for (int k = 0; k < cnt; k++) begin
                            automatic int sa = 16  + (sf ? 0 : k * b);
                            automatic int da = 128 + (df ? 0 : k * b);
                            automatic logic [7:0] t [4];
                            for (int j = 0; j < b; j++) t[j] = exp_m[(sa + j) & 255];
                            for (int j = 0; j < b; j++) exp_m[(da + j) & 255] = t[j];
                        end
                        clear_mon();
                        setup(1'b0, 16, 128, cnt);
                        wr(1'b0, 2'd3, ctl(sz, sf, df, bu, 0, 1, 1, 0));
                        wait_quiet();
                        for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) bad++;
                        check(bad == 0, "R3/R4 memory image mismatches", bad, 0);
                        check(wcnt == cnt, "R2 transfer count", wcnt, cnt);
                        if (bu) check(falls == 1, "R8 burst single release", falls, 1);
                        else    check(falls == cnt, "R7 release per transfer", falls, cnt);
                        check(irq[0] == 1, "R10 done irq", int'(irq[0]), 1);
                    end

        // R2 count 0 means 65536
        clear_mon();
        setup(1'b0, 16, 128, 0);
        wr(1'b0, 2'd3, ctl(0, 1, 1, 1, 0, 1, 1, 0));
        wait_quiet();
        check(wcnt == 65536, "R2 zero count", wcnt, 65536);
        check(falls == 1, "R8 long burst", falls, 1);

        // R9 external request
        clear_mon();
        setup(1'b0, 16, 128, 3);
        wr(1'b0, 2'd3, ctl(0, 0, 0, 0, 1, 1, 1, 0));
        repeat (10) @(negedge clk);
        check(acc == 0, "R9 no cycle without ext_req", acc, 0);
        ext_req[0] = 1'b1; @(negedge clk); ext_req[0] = 1'b0;
        wait_quiet();
        check(wcnt == 1, "R9 one request one transfer", wcnt, 1);
        ext_req[0] = 1'b1; wait_quiet(); ext_req[0] = 1'b0;
        check(wcnt == 3, "R9 remaining transfers", wcnt, 3);

        // R5 fixed priority
        clear_mon();
        setup(1'b0, 16, 128, 2);
        setup(1'b1, 32, 192, 2);
        wr(1'b0, 2'd3, ctl(0, 0, 0, 0, 1, 1, 1, 0));
        wr(1'b1, 2'd3, ctl(0, 0, 0, 0, 1, 1, 1, 0));
        ext_req = 2'b11; wait_quiet(); ext_req = 2'b00;
        check(wcnt == 4, "R5 total", wcnt, 4);
        check(wlog[0] == 128 && wlog[1] == 129 && wlog[2] == 192 && wlog[3] == 193,
              "R5 order (first,second)", int'(wlog[0]), 128);
        check(wlog[1] == 129, "R5 second winner", int'(wlog[1]), 129);

        // R6 round robin
        prio_rr = 1'b1;
        clear_mon();
        setup(1'b0, 16, 128, 2);
        setup(1'b1, 32, 192, 2);
        wr(1'b0, 2'd3, ctl(0, 0, 0, 0, 1, 1, 1, 0));
        wr(1'b1, 2'd3, ctl(0, 0, 0, 0, 1, 1, 1, 0));
        ext_req = 2'b11; wait_quiet(); ext_req = 2'b00;
        check(wcnt == 4, "R6 total", wcnt, 4);
        for (int i = 1; i < 4; i++)
            check(wlog[i][6] != wlog[i-1][6], "R6 alternation", int'(wlog[i]), int'(wlog[i-1]));
        prio_rr = 1'b0;

        // R10 masking and clearing
        clear_mon();
        setup(1'b1, 16, 192, 1);
        wr(1'b1, 2'd3, ctl(0, 0, 0, 0, 0, 0, 1, 0));
        wait_quiet();
        check(wcnt == 1 && irq[1] == 0, "R10 masked irq", int'(irq[1]), 0);
        wr(1'b1, 2'd3, ctl(0, 0, 0, 0, 0, 1, 0, 0));
        @(negedge clk);
        check(irq[1] == 1, "R10 flag kept under mask", int'(irq[1]), 1);
        wr(1'b1, 2'd3, ctl(0, 0, 0, 0, 0, 1, 0, 1));
        @(negedge clk);
        check(irq[1] == 0, "R10 clear", int'(irq[1]), 0);

        // R11 misalignment
        wr(1'b0, 2'd3, ctl(0, 0, 0, 0, 0, 1, 0, 1));
        clear_mon();
        setup(1'b0, 17, 128, 2);
        wr(1'b0, 2'd3, ctl(2, 0, 0, 0, 0, 1, 1, 0));
        wait_quiet();
        check(err_flag[0] == 1, "R11 error flag", int'(err_flag[0]), 1);
        check(irq[0] == 1, "R11 error irq", int'(irq[0]), 1);
        check(acc == 0, "R11 no memory cycle", acc, 0);
        wr(1'b0, 2'd3, ctl(0, 0, 0, 0, 0, 1, 0, 1));
        @(negedge clk);
        check(err_flag[0] == 0, "R11 cleared", int'(err_flag[0]), 0);
        setup(1'b0, 16, 128, 1);
        wr(1'b0, 2'd3, ctl(3, 0, 0, 0, 0, 1, 1, 0));
        wait_quiet();
        check(err_flag[0] == 1 && acc == 0, "R11 size code 3", acc, 0);

        // R12 grant
        wr(1'b0, 2'd3, ctl(0, 0, 0, 0, 0, 1, 0, 1));
        clear_mon();
        gnt_hold = 1'b1;
        setup(1'b0, 16, 128, 1);
        wr(1'b0, 2'd3, ctl(0, 0, 0, 0, 0, 1, 1, 0));
        repeat (8) @(negedge clk);
        check(bus_req == 1, "R12 request pending", int'(bus_req), 1);
        check(acc == 0, "R12 no cycle without grant", acc, 0);
        gnt_hold = 1'b0;
        wait_quiet();
        check(wcnt == 1, "R12 completes after grant", wcnt, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule